// File: doc/BRIEF.md
# Serial Control Port for a Precision DAC: Clear, Reset and Recalibration Flag

This block is the digital control front end of a high-resolution digital-to-analog converter. A host writes and reads 32-bit command words over a four-wire serial link. Each word has a direction flag, a seven-bit register address and a 24-bit payload. The block keeps the converter's data word, an 8-bit clear code, a small configuration and status register, and a self-clearing action register. It produces the code that the converter would receive, a serial read-back stream, and an active-low alarm line that is modelled as an open-drain pull-down.

Every pin (serial clock, frame select, serial data in and the clear pin) is brought into the system clock domain by a synchronizer of equal length. All serial edges are therefore handled as single-cycle strobes in one clock domain, so the system clock must run several times faster than the serial clock. A command takes effect when the frame select rises after exactly 32 bits. The one exception is a software clear in chained-output mode, which acts on the 32nd falling serial clock edge. A read command schedules its reply, which is shifted out during the following frame.

Top module: `dac_serial_ctrl`

## Requirements
- R1: While `sync_n` is low, SDI is sampled on each falling SCLK edge, MSB first, into a 32-bit word: bit 31 = 1 for read and 0 for write, bits 30:24 hold the address, bits 23:0 hold the payload. The word is acted on when `sync_n` rises, and each pin change reaches the logic after a 2-stage synchronizer.
- R2: A frame whose `sync_n` rises after any bit count other than 32 (for example 31 or 33) causes no register change and no action.
- R3: Address 03h holds the 8-bit clear code in payload bits 23:16. Bits 15:0 are ignored and read back as 0. The reset value is 80h.
- R4: Address 01h holds the DAC word, DAC_BITS wide, left-justified in the payload (bits 23:4 for 20 bits). It drives `dac_code` and resets to 0.
- R5: While the synchronized `clr_n` is low, `dac_code` is loaded every cycle with the clear code followed by DAC_BITS-8 zero bits. This takes priority over a write to 01h that completes in the same cycle.
- R6: Writing bit 5 of address 04h loads the left-justified clear code into the DAC word. With the chain-mode bit at 0, this happens when `sync_n` rises and not before.
- R7: With the chain-mode bit (address 05h, bit 2) set to 1, the software clear takes effect on the 32nd falling SCLK edge, before `sync_n` rises.
- R8: Writing bit 6 of address 04h returns every register to its default: DAC word 0, clear code 80h, alarm enable 0, chain mode 0, alarm flag 0, recalibration idle, and no pending reply.
- R9: Writing bit 8 of address 04h starts a 16-cycle recalibration and then sets the alarm flag (address 05h, bit 0). `alarm_n` is low exactly when the flag is 1 and the enable bit (address 05h, bit 1) is 1.
- R10: A read of address 05h clears the alarm flag, unless recalibration completes in the same cycle, in which case the flag is set.
- R11: After a read frame, the next frame shifts out {1, address, payload} MSB first on `sdo`, which changes after rising SCLK edges. Address 04h reads as 0 because its bits clear themselves. `sdo` is 0 while `sync_n` is high and in any frame that has no pending reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| sync_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data from the host |
| clr_n | input | 1 | Asynchronous clear request pin, active low |
| sdo | output | 1 | Serial read-back data |
| alarm_n | output | 1 | Alarm line, low when the alarm is active |
| dac_code | output | DAC_BITS | Code presented to the converter |

## Verification
The collision that matters most is the clear pin being sampled low in the same clock cycle that a write to the DAC word completes. The bench provokes it by driving `clr_n` low on the same clock as `sync_n` rises. Both pins pass through synchronizers of equal length, so the two events reach the logic together. The case is judged by requiring `dac_code` to equal the clear code rather than the written word, and a behavioural model compares every clock. A second coincidence, a status read meeting recalibration completion, is resolved by the same model in favour of setting the flag.

// File: rtl/dacsr_pkg.sv
// Shared constants and the frame layout for the DAC serial control block.
// Assumes a 32-bit frame with read flag, 7-bit address and 24-bit payload.
package dacsr_pkg;
    localparam int          FRAME_BITS   = 32;
    localparam logic [6:0]  ADDR_DAC     = 7'h01;
    localparam logic [6:0]  ADDR_CLRCODE = 7'h03;
    localparam logic [6:0]  ADDR_ACTION  = 7'h04;
    localparam logic [6:0]  ADDR_STATUS  = 7'h05;
    localparam int          ACT_RECAL    = 8;
    localparam int          ACT_SWRST    = 6;
    localparam int          ACT_SWCLR    = 5;
    localparam int          ST_ALARM     = 0;
    localparam int          ST_ALM_EN    = 1;
    localparam int          ST_CHAIN     = 2;
    localparam logic [7:0]  CLR_CODE_DEF = 8'h80;

    typedef struct packed {
        logic        rd;
        logic [6:0]  addr;
        logic [23:0] data;
    } frame_t;
endpackage

// File: rtl/dacsr_sync.sv
// Multi-stage synchronizer for a vector of independent pins.
// Assumes each bit is an unrelated level; resets to a given idle pattern.
module dacsr_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacsr_frontend.sv
// Serial front end: synchronizes pins, detects SCLK/SYNC edges, assembles
// the incoming 32-bit word and shifts read-back data out on SDO.
// Assumes clk is at least ~8x SCLK so every serial edge is seen.
module dacsr_frontend
    import dacsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        sync_n,
    input  logic        sdi,
    input  logic        clr_n,
    input  logic [31:0] reply_word,
    output logic        sdo,
    output logic        sync_low,
    output logic        frame_start,
    output logic        frame_ok,
    output logic        last_fall,
    output frame_t      word,
    output frame_t      word_next,
    output logic        clr_low
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    logic [3:0]       pins_s;
    logic             sclk_d, sync_d;
    logic             sclk_fall, sclk_rise, sync_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic [31:0]      rx_sh, tx_sh;
    logic             sdo_q;

    dacsr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sync_n, sdi, clr_n}),
        .q     (pins_s)
    );

    // Remember last synchronized SCLK and SYNC levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sync_d <= 1'b1;
        end else begin
            sclk_d <= pins_s[3];
            sync_d <= pins_s[2];
        end
    end

    assign sync_low    = !pins_s[2];
    assign frame_start = sync_d && !pins_s[2];
    assign sync_rise   = !sync_d && pins_s[2];
    assign sclk_fall   = sync_low && sclk_d && !pins_s[3];
    assign sclk_rise   = sync_low && !sclk_d && pins_s[3];
    assign clr_low     = !pins_s[0];

    // Count and capture incoming bits; count saturates one past full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (frame_start) begin
            bit_cnt <= '0;
        end else if (sclk_fall) begin
            rx_sh <= {rx_sh[30:0], pins_s[1]};
            if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign word      = rx_sh;
    assign word_next = {rx_sh[30:0], pins_s[1]};
    assign frame_ok  = sync_rise && (bit_cnt == CNT_FULL);
    assign last_fall = sclk_fall && (bit_cnt == CNT_FULL - 1'b1);

    // Load the pending reply at frame start and present one bit per rising SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            sdo_q <= 1'b0;
        end else if (!sync_low) begin
            sdo_q <= 1'b0;
        end else if (frame_start) begin
            tx_sh <= reply_word;
            sdo_q <= 1'b0;
        end else if (sclk_rise) begin
            sdo_q <= tx_sh[31];
            tx_sh <= {tx_sh[30:0], 1'b0};
        end
    end

    assign sdo = sdo_q;
endmodule

// File: rtl/dacsr_recal.sv
// Recalibration model: a fixed busy countdown that sets a sticky alarm flag.
// Assumes start requests while busy are dropped; completion beats read-clear.
module dacsr_recal #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sw_rst,
    input  logic rd_clear,
    output logic busy,
    output logic alarm
);
    localparam int BW = $clog2(CYCLES + 1);
    localparam logic [BW-1:0] LOAD = BW'(CYCLES);

    logic [BW-1:0] left;
    logic          done;

    assign done = (left == BW'(1));

    // Run the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)          left <= '0;
        else if (start && left == '0)  left <= LOAD;
        else if (left != '0)           left <= left - 1'b1;
    end

    // Keep the alarm flag: set on completion, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) alarm <= 1'b0;
        else if (done)        alarm <= 1'b1;
        else if (rd_clear)    alarm <= 1'b0;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/dacsr_regfile.sv
// Register storage and command decode: DAC word, clear code, configuration,
// action pulses, clear handling and read-back word formation.
// Assumes DAC_BITS between 8 and 24; frame_ok and last_fall are one-cycle strobes.
module dacsr_regfile
    import dacsr_pkg::*;
#(
    parameter int DAC_BITS = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                frame_ok,
    input  logic                last_fall,
    input  frame_t              word,
    input  frame_t              word_next,
    input  logic                clr_low,
    input  logic                alarm,
    output logic [DAC_BITS-1:0] dac_code,
    output logic [7:0]          clear_code,
    output logic                alarm_en,
    output logic                sw_rst,
    output logic                recal_start,
    output logic                rd_clear,
    output logic [31:0]         reply_word
);
    localparam int PAD = DAC_BITS - 8;

    logic                wr, rd, chain_mode, chain_clr, frame_clr;
    logic [DAC_BITS-1:0] dac_d, clr_word, clr_word_rst;
    logic [7:0]          code_d;
    logic                en_d, chain_d;
    logic [31:0]         reply_d;
    logic [23:0]         rd_payload;

    assign wr  = frame_ok && !word.rd;
    assign rd  = frame_ok &&  word.rd;

    assign sw_rst      = wr && word.addr == ADDR_ACTION && word.data[ACT_SWRST];
    assign recal_start = wr && word.addr == ADDR_ACTION && word.data[ACT_RECAL] && !sw_rst;
    assign rd_clear    = rd && word.addr == ADDR_STATUS;
    assign frame_clr   = wr && word.addr == ADDR_ACTION && word.data[ACT_SWCLR] && !chain_mode;
    assign chain_clr   = last_fall && chain_mode && !word_next.rd &&
                         word_next.addr == ADDR_ACTION && word_next.data[ACT_SWCLR];

    assign clr_word     = {clear_code, {PAD{1'b0}}};
    assign clr_word_rst = {CLR_CODE_DEF, {PAD{1'b0}}};

    // Form the read-back payload for the addressed register.
    always_comb begin
        case (word.addr)
            ADDR_DAC:     rd_payload = {dac_code, {(24-DAC_BITS){1'b0}}};
            ADDR_CLRCODE: rd_payload = {clear_code, 16'h0000};
            ADDR_STATUS:  rd_payload = {21'h0, chain_mode, alarm_en, alarm};
            default:      rd_payload = 24'h0;
        endcase
    end

    // Work out next register values; the clear pin overrides the DAC word last.
    always_comb begin
        dac_d   = dac_code;
        code_d  = clear_code;
        en_d    = alarm_en;
        chain_d = chain_mode;
        reply_d = reply_word;
        if (sw_rst) begin
            dac_d   = '0;
            code_d  = CLR_CODE_DEF;
            en_d    = 1'b0;
            chain_d = 1'b0;
            reply_d = '0;
        end else begin
            if (frame_start) reply_d = '0;
            if (rd) reply_d = {1'b1, word.addr, rd_payload};
            if (wr && word.addr == ADDR_DAC)     dac_d  = word.data[23 -: DAC_BITS];
            if (wr && word.addr == ADDR_CLRCODE) code_d = word.data[23:16];
            if (wr && word.addr == ADDR_STATUS) begin
                en_d    = word.data[ST_ALM_EN];
                chain_d = word.data[ST_CHAIN];
            end
            if (frame_clr || chain_clr) dac_d = clr_word;
        end
        if (clr_low) dac_d = sw_rst ? clr_word_rst : clr_word;
    end

    // Register the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code   <= '0;
            clear_code <= CLR_CODE_DEF;
            alarm_en   <= 1'b0;
            chain_mode <= 1'b0;
            reply_word <= '0;
        end else begin
            dac_code   <= dac_d;
            clear_code <= code_d;
            alarm_en   <= en_d;
            chain_mode <= chain_d;
            reply_word <= reply_d;
        end
    end
endmodule

// File: rtl/dac_serial_ctrl.sv
// Top of the DAC serial control block: front end, register file and
// recalibration model, plus the open-drain style alarm output.
// Assumes clk runs several times faster than sclk.
module dac_serial_ctrl
    import dacsr_pkg::*;
#(
    parameter int DAC_BITS     = 20,
    parameter int SYNC_STAGES  = 2,
    parameter int RECAL_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                sync_n,
    input  logic                sdi,
    input  logic                clr_n,
    output logic                sdo,
    output logic                alarm_n,
    output logic [DAC_BITS-1:0] dac_code
);
    logic        sync_low, frame_start, frame_ok, last_fall, clr_low;
    frame_t      word, word_next;
    logic [31:0] reply_word;
    logic [7:0]  clear_code;
    logic        alarm_en, sw_rst, recal_start, rd_clear;
    logic        recal_busy, alarm_flag;

    dacsr_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .sync_n      (sync_n),
        .sdi         (sdi),
        .clr_n       (clr_n),
        .reply_word  (reply_word),
        .sdo         (sdo),
        .sync_low    (sync_low),
        .frame_start (frame_start),
        .frame_ok    (frame_ok),
        .last_fall   (last_fall),
        .word        (word),
        .word_next   (word_next),
        .clr_low     (clr_low)
    );

    dacsr_regfile #(.DAC_BITS(DAC_BITS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_ok    (frame_ok),
        .last_fall   (last_fall),
        .word        (word),
        .word_next   (word_next),
        .clr_low     (clr_low),
        .alarm       (alarm_flag),
        .dac_code    (dac_code),
        .clear_code  (clear_code),
        .alarm_en    (alarm_en),
        .sw_rst      (sw_rst),
        .recal_start (recal_start),
        .rd_clear    (rd_clear),
        .reply_word  (reply_word)
    );

    dacsr_recal #(.CYCLES(RECAL_CYCLES)) u_recal (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (recal_start),
        .sw_rst   (sw_rst),
        .rd_clear (rd_clear),
        .busy     (recal_busy),
        .alarm    (alarm_flag)
    );

    // Pull the alarm line low only when the flag is up and enabled.
    assign alarm_n = !(alarm_flag && alarm_en);
endmodule

// File: rtl/dacsr_checker.sv
// Temporal checks on the DAC serial control block, bound into its top.
module dacsr_checker #(
    parameter int DAC_BITS = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sdo,
    input logic [DAC_BITS-1:0] dac_code,
    input logic                clr_low,
    input logic                sync_low,
    input logic                frame_ok,
    input logic                last_fall,
    input logic [7:0]          clear_code,
    input logic                alarm_flag,
    input logic                recal_busy,
    input logic                sw_rst
);
    // R5
    clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_low && !sw_rst) |=> dac_code == {$past(clear_code), {(DAC_BITS-8){1'b0}}});

    // R2
    dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_ok && !last_fall && !clr_low) |=> $stable(dac_code));

    // R9
    alarm_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(recal_busy));

    // R11
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_low |=> !sdo);

    // R8
    swrst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (clear_code == 8'h80) && !alarm_flag && !recal_busy);
endmodule

bind dac_serial_ctrl dacsr_checker #(.DAC_BITS(DAC_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdo        (sdo),
    .dac_code   (dac_code),
    .clr_low    (clr_low),
    .sync_low   (sync_low),
    .frame_ok   (frame_ok),
    .last_fall  (last_fall),
    .clear_code (clear_code),
    .alarm_flag (alarm_flag),
    .recal_busy (recal_busy),
    .sw_rst     (sw_rst)
);

// File: tb/test_dac_serial_ctrl.sv
// Bench: directed serial frames plus a behavioural per-clock model.
module test_dac_serial_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DB   = 20;
    localparam int HALF = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, sync_n = 1'b1, sdi = 1'b0, clr_n = 1'b1;
    logic sdo, alarm_n;
    logic [DB-1:0] dac_code;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] rx;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_ctrl #(.DAC_BITS(DB)) i_dac_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
        .clr_n(clr_n), .sdo(sdo), .alarm_n(alarm_n), .dac_code(dac_code)
    );

    // ---------------- behavioural reference model ----------------
    bit h_sclk[4], h_sync[4], h_sdi[4], h_clr[4];
    int m_cnt;
    bit [31:0] m_sh, m_tx, m_pend;
    bit m_sdo, m_en, m_mode, m_alarm;
    bit [7:0] m_code;
    bit [DB-1:0] m_dac;
    int m_busy;

    function automatic bit [DB-1:0] lj(input bit [7:0] c);
        return {c, {(DB-8){1'b0}}};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                h_sclk[k] = 0; h_sync[k] = 1; h_sdi[k] = 0; h_clr[k] = 1;
            end
            m_cnt = 0; m_sh = 0; m_tx = 0; m_pend = 0; m_sdo = 0;
            m_en = 0; m_mode = 0; m_alarm = 0; m_code = 8'h80; m_dac = 0; m_busy = 0;
        end else begin
            bit slo, sfall, srise, ffall, frise, bitin, clrlo, ok, lastf, wr, rd, srst;
            bit [31:0] w, wn, reply;
            bit [6:0] a;
            bit [DB-1:0] nd;
            bit [7:0] ncode;
            bit nen, nmode, nal;
            int nbusy;
            for (int k = 3; k > 0; k--) begin
                h_sclk[k] = h_sclk[k-1]; h_sync[k] = h_sync[k-1];
                h_sdi[k] = h_sdi[k-1];   h_clr[k] = h_clr[k-1];
            end
            h_sclk[0] = sclk; h_sync[0] = sync_n; h_sdi[0] = sdi; h_clr[0] = clr_n;
            slo   = !h_sync[2];
            sfall = h_sync[3] && !h_sync[2];
            srise = !h_sync[3] && h_sync[2];
            ffall = slo && h_sclk[3] && !h_sclk[2];
            frise = slo && !h_sclk[3] && h_sclk[2];
            bitin = h_sdi[2];
            clrlo = !h_clr[2];
            w  = m_sh;
            wn = {m_sh[30:0], bitin};
            ok    = srise && m_cnt == 32;
            lastf = ffall && m_cnt == 31;
            wr = ok && !w[31];
            rd = ok && w[31];
            a  = w[30:24];
            srst = wr && a == 7'h04 && w[6];
            case (a)
                7'h01: reply = {1'b1, a, m_dac, 4'h0};
                7'h03: reply = {1'b1, a, m_code, 16'h0};
                7'h05: reply = {1'b1, a, 21'h0, m_mode, m_en, m_alarm};
                default: reply = {1'b1, a, 24'h0};
            endcase
            // serial output
            if (!slo) m_sdo = 0;
            else if (sfall) begin m_tx = m_pend; m_sdo = 0; end
            else if (frise) begin m_sdo = m_tx[31]; m_tx = m_tx << 1; end
            // registers
            nd = m_dac; ncode = m_code; nen = m_en; nmode = m_mode;
            if (srst) begin
                nd = 0; ncode = 8'h80; nen = 0; nmode = 0; m_pend = 0;
            end else begin
                if (sfall) m_pend = 0;
                if (rd) m_pend = reply;
                if (wr && a == 7'h01) nd = w[23:24-DB];
                if (wr && a == 7'h03) ncode = w[23:16];
                if (wr && a == 7'h05) begin nen = w[1]; nmode = w[2]; end
                if (wr && a == 7'h04 && w[5] && !m_mode) nd = lj(m_code);
                if (lastf && m_mode && !wn[31] && wn[30:24] == 7'h04 && wn[5]) nd = lj(m_code);
            end
            if (clrlo) nd = srst ? lj(8'h80) : lj(m_code);
            // recalibration
            if (srst) begin nbusy = 0; nal = 0; end
            else begin
                nbusy = (wr && a == 7'h04 && w[8] && m_busy == 0) ? 16 :
                        (m_busy > 0 ? m_busy - 1 : 0);
                nal = (m_busy == 1) ? 1'b1 : ((rd && a == 7'h05) ? 1'b0 : m_alarm);
            end
            // frame counter
            if (sfall) m_cnt = 0;
            else if (ffall) begin m_sh = wn; if (m_cnt < 33) m_cnt++; end
            m_dac = nd; m_code = ncode; m_en = nen; m_mode = nmode;
            m_busy = nbusy; m_alarm = nal;
        end
    end

    // Compare the design against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (dac_code !== m_dac) begin
                errors++;
                $display("FAIL R4 model dac_code actual %h expected %h at %0t", dac_code, m_dac, $time);
            end else if (alarm_n !== !(m_alarm && m_en)) begin
                errors++;
                $display("FAIL R9 model alarm_n actual %b expected %b at %0t", alarm_n, !(m_alarm && m_en), $time);
            end else if (sdo !== m_sdo) begin
                errors++;
                $display("FAIL R11 model sdo actual %b expected %b at %0t", sdo, m_sdo, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_bits(input logic [31:0] w, input int nbits);
        rx = '0;
        @(negedge clk); sync_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1; sdi = (i < 32) ? w[31-i] : 1'b0;
            wait_clk(HALF);
            rx = {rx[30:0], sdo};
            sclk = 1'b0;
            wait_clk(HALF);
        end
    endtask

    task automatic frame_end(input bit drop_clr);
        sync_n = 1'b1;
        if (drop_clr) clr_n = 1'b0;
        wait_clk(2*HALF);
    endtask

    task automatic send(input logic [31:0] w);
        frame_bits(w, 32);
        frame_end(0);
    endtask

    task automatic read_reg(input logic [6:0] a, output logic [31:0] r);
        send({1'b1, a, 24'h0});
        send({1'b0, 7'h7F, 24'h0});
        r = rx;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] r;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R4 reset dac_code", 32'(dac_code), 32'h0);
        chk("R9 reset alarm_n", 32'(alarm_n), 32'h1);
        chk("R11 reset sdo", 32'(sdo), 32'h0);

        read_reg(7'h03, r);
        chk("R3 R11 default clear code readback", r, 32'h83800000);

        send(32'h01ABCDE0);
        chk("R1 R4 dac write", 32'(dac_code), 32'hABCDE);

        frame_bits(32'h01123450, 31); frame_end(0);
        chk("R2 short frame ignored", 32'(dac_code), 32'hABCDE);
        frame_bits(32'h01123450, 33); frame_end(0);
        chk("R2 long frame ignored", 32'(dac_code), 32'hABCDE);

        send(32'h035AFFFF);
        read_reg(7'h03, r);
        chk("R3 clear code with low bits ignored", r, 32'h835A0000);

        clr_n = 1'b0; wait_clk(5);
        chk("R5 clr pin loads code", 32'(dac_code), 32'h5A000);
        send(32'h01000010);
        chk("R5 write blocked while clr low", 32'(dac_code), 32'h5A000);
        clr_n = 1'b1; wait_clk(5);
        chk("R5 value held after release", 32'(dac_code), 32'h5A000);
        send(32'h01000010);
        chk("R4 write after clr release", 32'(dac_code), 32'h00001);

        frame_bits(32'h01000020, 32); frame_end(1);
        wait_clk(3);
        chk("R5 clr wins over same-cycle write", 32'(dac_code), 32'h5A000);
        clr_n = 1'b1; wait_clk(5);

        send(32'h01000010);
        frame_bits(32'h04000020, 32); wait_clk(4);
        chk("R6 no clear before sync rise", 32'(dac_code), 32'h00001);
        frame_end(0);
        chk("R6 clear on sync rise", 32'(dac_code), 32'h5A000);

        send(32'h05000004);
        send(32'h01000010);
        frame_bits(32'h04000020, 32); wait_clk(4);
        chk("R7 chain-mode clear on 32nd fall", 32'(dac_code), 32'h5A000);
        frame_end(0);

        send(32'h05000002);
        send(32'h04000100);
        wait_clk(5);
        chk("R9 alarm not yet during busy", 32'(alarm_n), 32'h1);
        wait_clk(20);
        chk("R9 alarm pulled low when enabled", 32'(alarm_n), 32'h0);
        read_reg(7'h05, r);
        chk("R9 status shows alarm and enable", r, 32'h85000003);
        chk("R10 status read released alarm", 32'(alarm_n), 32'h1);
        read_reg(7'h05, r);
        chk("R10 flag cleared by read", r, 32'h85000002);

        send(32'h05000000);
        send(32'h04000100);
        wait_clk(25);
        chk("R9 disabled alarm stays high", 32'(alarm_n), 32'h1);
        read_reg(7'h04, r);
        chk("R11 action register reads zero", r, 32'h84000000);

        send(32'h05000006);
        send(32'h01FFFFF0);
        send(32'h04000040);
        chk("R8 reset clears dac", 32'(dac_code), 32'h0);
        read_reg(7'h03, r);
        chk("R8 reset restores clear code", r, 32'h83800000);
        read_reg(7'h05, r);
        chk("R8 reset clears status", r, 32'h85000000);
        read_reg(7'h01, r);
        chk("R11 dac readback", r, 32'h81000000);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule